// File: doc/BRIEF.md
# Real-Mode Address Gate

This block turns a 16-bit segment and a 16-bit offset into a physical bus address the way an early 20-bit processor does. The segment is multiplied by sixteen and added to the offset. The sum can carry into a twenty-first bit. A gate bit held in a byte-wide control port decides whether that top bit reaches the bus. With the gate closed, the top bit is forced low and addresses above one megabyte wrap to the bottom of memory. With the gate open, the computed value passes through and memory above one megabyte is reachable.

The result is registered once and presented with a valid flag. The gating happens before the register. Any cache placed after this block therefore indexes and tags with the address that actually reaches memory. Two aliases of one segment:offset pair can never share a cached line across a gate change. The block also emits a one-cycle pulse each time the gate bit flips, so a downstream cache can flush if it chooses to.

Top module: `rm_addr_gate`

## Requirements
- R1: For every accepted request, physAddr bits 19..0 equal bits 19..0 of (segment × 16 + offset), whatever the gate state.
- R2: With the gate open, segment FFFF and offset FFFF give physAddr 10FFEF hex; with the gate closed, they give 0FFEF hex.
- R3: With the gate closed, physAddr bit 20 is 0 for every request; segment FFFF with offset 0010 gives 000000 hex.
- R4: With the gate open, physAddr bit 20 equals bit 20 of the computed sum; segment FFFF with offset 0010 gives 100000 hex.
- R5: A write (portWrEn high) loads portWrData into the 8-bit control port (visible on ctrlPort one cycle later). Bit 1 of that byte is the gate: 1 opens it, 0 closes it. The other seven bits are stored but do not affect the address.
- R6: After reset, ctrlPort is 00 hex (gate closed), addrValid is 0, physAddr is 0 and gateChanged is 0.
- R7: A gate write accepted on a clock edge applies to requests presented from the next cycle on. A request presented in the same cycle as the write still uses the previous gate.
- R8: gateChanged is high for exactly the one cycle after a write that flips the gate bit. A write that leaves bit 1 unchanged produces no pulse.
- R9: addrValid is high in the cycle after a request (reqValid high) and low otherwise; physAddr holds its last value while no request arrives.
- R10: Reading FFFF:0010 with the gate open gives 100000 hex. If the gate is then closed and the same read repeated, the result is 000000 hex, so no result for the 1 MB alias is reused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Address request strobe |
| segment | input | 16 | Segment value of the request |
| offset | input | 16 | Offset value of the request |
| portWrEn | input | 1 | Control port write strobe |
| portWrData | input | 8 | Byte written to the control port; bit 1 is the gate |
| addrValid | output | 1 | physAddr carries a new result this cycle |
| physAddr | output | 21 | Gated physical address |
| gateChanged | output | 1 | One-cycle pulse after the gate bit flips |
| ctrlPort | output | 8 | Current control port byte |

## Verification
Several properties are checked on every cycle:
- the one-cycle latency of addrValid and the holding of physAddr between requests;
- the lower twenty address bits against the segment and offset;
- bit 20 against the gate state;
- the loading of the control port;
- the pairing of each gateChanged pulse with a flip of the gate bit.

Some behaviour only the bench's scenarios can show. These are the exact corner values FFFF:FFFF and FFFF:0010 under both gate states, and a write and a request landing in the same cycle. They also include the open-read, close, re-read sequence that proves the 1 MB alias is not returned.

// File: rtl/rm_gate_pkg.sv
package rm_gate_pkg;

  // Default geometry of a 20-bit real-mode machine.
  localparam int SEG_W     = 16;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PORT_W    = 8;
  localparam int GATE_BIT  = 1;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // register a new address this cycle
    logic passTop;   // let the carry bit through to the bus
  } gateStrobe_t;

endpackage

// File: rtl/rm_gate_ctrl.sv
module rm_gate_ctrl
  import rm_gate_pkg::*;
#(
  parameter int PORT_W   = rm_gate_pkg::PORT_W,
  parameter int GATE_BIT = rm_gate_pkg::GATE_BIT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              portWrEn,
  input  logic [PORT_W-1:0] portWrData,
  output gateStrobe_t       strobe,
  output logic [PORT_W-1:0] ctrlPort,
  output logic              gateChanged
);

  logic [PORT_W-1:0] portQ;
  logic              changeQ;
  logic              gateNow;
  logic              gateFlip;

  assign gateNow  = portQ[GATE_BIT];
  assign gateFlip = portWrEn && (portWrData[GATE_BIT] != gateNow);

  // Control port byte; reset closes the gate.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portQ <= '0;
    end else if (portWrEn) begin
      portQ <= portWrData;
    end
  end

  // Flip pulse for a downstream cache.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      changeQ <= 1'b0;
    end else begin
      changeQ <= gateFlip;
    end
  end

  // The datapath sees the gate as registered; a write this cycle
  // only affects requests from the next cycle on.
  always_comb begin
    strobe.capture = reqValid;
    strobe.passTop = gateNow;
  end

  assign ctrlPort    = portQ;
  assign gateChanged = changeQ;

endmodule

// File: rtl/rm_gate_dp.sv
module rm_gate_dp
  import rm_gate_pkg::*;
#(
  parameter int SEG_W     = rm_gate_pkg::SEG_W,
  parameter int OFF_W     = rm_gate_pkg::OFF_W,
  parameter int SEG_SHIFT = rm_gate_pkg::SEG_SHIFT,
  parameter int ADDR_W    = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [SEG_W-1:0]  segment,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] physAddr,
  output logic              addrValid
);

  localparam int TOP = ADDR_W - 1;

  logic [ADDR_W-1:0] segBase;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] linSum;
  logic [ADDR_W-1:0] gatedAddr;
  logic [ADDR_W-1:0] addrQ;
  logic              validQ;

  assign segBase = ADDR_W'(segment) << SEG_SHIFT;
  assign offExt  = ADDR_W'(offset);
  assign linSum  = segBase + offExt;

  // Only the carry bit is gated; the lower bits pass straight through.
  genvar b;
  generate
    for (b = 0; b < ADDR_W; b++) begin : g_mask
      if (b == TOP) begin : g_top
        assign gatedAddr[b] = linSum[b] & strobe.passTop;
      end else begin : g_low
        assign gatedAddr[b] = linSum[b];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobe.capture;
      if (strobe.capture) begin
        addrQ <= gatedAddr;
      end
    end
  end

  assign physAddr  = addrQ;
  assign addrValid = validQ;

endmodule

// File: rtl/rm_addr_gate.sv
module rm_addr_gate
  import rm_gate_pkg::*;
#(
  parameter int SEG_W     = rm_gate_pkg::SEG_W,
  parameter int OFF_W     = rm_gate_pkg::OFF_W,
  parameter int SEG_SHIFT = rm_gate_pkg::SEG_SHIFT,
  parameter int PORT_W    = rm_gate_pkg::PORT_W,
  parameter int GATE_BIT  = rm_gate_pkg::GATE_BIT,
  localparam int ADDR_W   = ((SEG_W + SEG_SHIFT) > OFF_W ? (SEG_W + SEG_SHIFT) : OFF_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  segment,
  input  logic [OFF_W-1:0]  offset,
  input  logic              portWrEn,
  input  logic [PORT_W-1:0] portWrData,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic              gateChanged,
  output logic [PORT_W-1:0] ctrlPort
);

  gateStrobe_t strobe;

  rm_gate_ctrl #(
    .PORT_W   (PORT_W),
    .GATE_BIT (GATE_BIT)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .portWrEn    (portWrEn),
    .portWrData  (portWrData),
    .strobe      (strobe),
    .ctrlPort    (ctrlPort),
    .gateChanged (gateChanged)
  );

  rm_gate_dp #(
    .SEG_W     (SEG_W),
    .OFF_W     (OFF_W),
    .SEG_SHIFT (SEG_SHIFT),
    .ADDR_W    (ADDR_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .segment   (segment),
    .offset    (offset),
    .physAddr  (physAddr),
    .addrValid (addrValid)
  );

endmodule

// File: rtl/rm_addr_gate_chk.sv
module rm_addr_gate_chk #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PORT_W    = 8,
  parameter int GATE_BIT  = 1,
  parameter int ADDR_W    = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [SEG_W-1:0]  segment,
  input logic [OFF_W-1:0]  offset,
  input logic              portWrEn,
  input logic [PORT_W-1:0] portWrData,
  input logic              addrValid,
  input logic [ADDR_W-1:0] physAddr,
  input logic              gateChanged,
  input logic [PORT_W-1:0] ctrlPort
);

  logic [ADDR_W-1:0] refSum;
  assign refSum = (ADDR_W'(segment) << SEG_SHIFT) + ADDR_W'(offset);

  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> physAddr[ADDR_W-2:0] == $past(refSum[ADDR_W-2:0])); // R1

  AST_TOP_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !ctrlPort[GATE_BIT]) |=> !physAddr[ADDR_W-1]); // R3

  AST_TOP_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ctrlPort[GATE_BIT]) |=> physAddr[ADDR_W-1] == $past(refSum[ADDR_W-1])); // R4

  AST_PORT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    portWrEn |=> ctrlPort == $past(portWrData)); // R5

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !portWrEn |=> $stable(ctrlPort)); // R5

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid); // R9

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!addrValid && $stable(physAddr))); // R9

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    gateChanged |-> ctrlPort[GATE_BIT] != $past(ctrlPort[GATE_BIT])); // R8

  AST_PULSE_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (portWrEn && (portWrData[GATE_BIT] != ctrlPort[GATE_BIT])) |=> gateChanged); // R8

endmodule

bind rm_addr_gate rm_addr_gate_chk #(
  .SEG_W     (SEG_W),
  .OFF_W     (OFF_W),
  .SEG_SHIFT (SEG_SHIFT),
  .PORT_W    (PORT_W),
  .GATE_BIT  (GATE_BIT),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .segment     (segment),
  .offset      (offset),
  .portWrEn    (portWrEn),
  .portWrData  (portWrData),
  .addrValid   (addrValid),
  .physAddr    (physAddr),
  .gateChanged (gateChanged),
  .ctrlPort    (ctrlPort)
);

// File: tb/rm_addr_gate_tb_top.sv
`timescale 1ns/1ps
module rm_addr_gate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] segment = '0;
  logic [15:0] offset = '0;
  logic        portWrEn = 1'b0;
  logic [7:0]  portWrData = '0;
  logic        addrValid;
  logic [20:0] physAddr;
  logic        gateChanged;
  logic [7:0]  ctrlPort;

  always #2 clk = ~clk;

  rm_addr_gate dut_i (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .segment (segment),
    .offset (offset), .portWrEn (portWrEn), .portWrData (portWrData),
    .addrValid (addrValid), .physAddr (physAddr),
    .gateChanged (gateChanged), .ctrlPort (ctrlPort)
  );

  int checks = 0;
  int fails = 0;
  bit started = 0;
  bit finished = 0;

  // Bench model state.
  bit         modelGate = 0;
  logic [7:0] modelPort = '0;
  bit         pendChange = 0;
  logic [7:0] pendPort = '0;
  bit         expChangeQ = 0;
  logic [7:0] expPortQ = '0;
  logic [20:0] lastAddr = '0;
  logic [31:0] rnd = 32'h1F2E3D4C;

  logic [20:0] expAddrQ[$];
  string       expTagQ[$];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] model(logic [15:0] s, logic [15:0] o, bit g);
    logic [20:0] sum;
    sum = {1'b0, s, 4'b0} + {5'b0, o};
    if (!g) sum[20] = 1'b0;
    return sum;
  endfunction

  function automatic logic [31:0] nextRnd(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Driver: one cycle per call, entered just after a falling edge.
  task automatic drive(bit req, logic [15:0] s, logic [15:0] o,
                       bit wr, logic [7:0] d, string tag);
    reqValid   = req;
    segment    = s;
    offset     = o;
    portWrEn   = wr;
    portWrData = d;
    if (req) begin
      expAddrQ.push_back(model(s, o, modelGate));
      expTagQ.push_back(tag);
    end
    pendChange = wr && (d[1] != modelGate);
    if (wr) begin
      modelPort = d;
      modelGate = d[1];
    end
    pendPort = modelPort;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    portWrEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, 0, '0, "");
  endtask

  always @(posedge clk) begin
    expChangeQ <= pendChange;
    expPortQ   <= pendPort;
  end

  // Monitor: compares outputs away from the active edge.
  always @(negedge clk) begin
    if (started && rstN) begin
      check(gateChanged == expChangeQ, "R8 gateChanged", 32'(gateChanged), 32'(expChangeQ));
      check(ctrlPort == expPortQ, "R5 ctrlPort", 32'(ctrlPort), 32'(expPortQ));
      if (addrValid) begin
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R9 unexpected addrValid", 32'(physAddr), 32'h0);
        end else begin
          logic [20:0] e;
          string t;
          e = expAddrQ.pop_front();
          t = expTagQ.pop_front();
          check(physAddr == e, t, 32'(physAddr), 32'(e));
        end
        lastAddr = physAddr;
      end else begin
        check(physAddr == lastAddr, "R9 hold", 32'(physAddr), 32'(lastAddr));
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check(ctrlPort == 8'h00, "R6 ctrlPort", 32'(ctrlPort), 32'h0);
    check(addrValid == 1'b0, "R6 addrValid", 32'(addrValid), 32'h0);
    check(physAddr == 21'h0, "R6 physAddr", 32'(physAddr), 32'h0);
    check(gateChanged == 1'b0, "R6 gateChanged", 32'(gateChanged), 32'h0);
    rstN = 1'b1;
    started = 1;
    idle(1);

    // R3 / R2 with the gate closed
    drive(1, 16'hFFFF, 16'h0010, 0, '0, "R3 FFFF:0010 closed");
    drive(1, 16'hFFFF, 16'hFFFF, 0, '0, "R2 FFFF:FFFF closed");
    idle(2);

    // Open the gate (R5, R8)
    drive(0, '0, '0, 1, 8'h02, "");
    drive(1, 16'hFFFF, 16'h0010, 0, '0, "R4 R10 FFFF:0010 open");
    drive(1, 16'hFFFF, 16'hFFFF, 0, '0, "R2 FFFF:FFFF open");

    // R7: close with a same-cycle request, then R10 re-read
    drive(1, 16'hFFFF, 16'h0010, 1, 8'h00, "R7 same-cycle old gate");
    drive(1, 16'hFFFF, 16'h0010, 0, '0, "R10 re-read after close");
    idle(1);

    // R5: other bits ignored, no pulse
    drive(0, '0, '0, 1, 8'hFD, "");
    drive(1, 16'hF800, 16'h8000, 0, '0, "R5 other bits ignored");
    drive(0, '0, '0, 1, 8'hFD, "");
    drive(0, '0, '0, 1, 8'h02, "");
    drive(0, '0, '0, 1, 8'h06, "");
    drive(1, 16'hF800, 16'h8000, 0, '0, "R4 F800:8000 open");
    idle(2);

    // R1: mixed patterns with random gate writes
    for (int i = 0; i < 200; i++) begin
      rnd = nextRnd(rnd);
      if (rnd[3:0] == 4'h5) begin
        drive(rnd[4], rnd[31:16], rnd[15:0], 1, rnd[27:20], "R1 mixed+write");
      end else if (rnd[3:0] == 4'hA) begin
        idle(1);
      end else begin
        drive(1, rnd[31:16], rnd[15:0] ^ rnd[23:8], 0, '0, "R1 mixed");
      end
    end
    idle(3);

    check(expAddrQ.size() == 0, "R9 queue drained", 32'(expAddrQ.size()), 32'h0);
    finished = 1;
    finishRun();
  end

endmodule